// File: doc/BRIEF.md
# MMD Indirect Access Sequencer

This block turns one request for a register inside a PHY's MMD device into four Clause-22 operations on an MDIO management bus. The host gives a PHY address, a 5-bit device address, a 16-bit register address, write data and a direction bit. The sequencer then programs the MMD control register with the address command, loads the register address, switches the control register to the data command, and finally writes or reads the data register. Read data comes back to the host together with a one-cycle done pulse.

Requests come in over a valid/ready handshake. `req_ready` is high only while the block is idle, and a request transfers on a clock edge where `req_valid` and `req_ready` are both high. While a request is running, `busy` is high and `req_ready` is low, so a waiting `req_valid` has no effect. Toward the MDIO frame engine, each Clause-22 operation is offered on `c22_valid` with its fields held steady until `c22_ready` accepts it. The block then waits for `c22_rsp_valid` before it offers the next operation, so only one operation is ever outstanding. The frame engine may stall on `c22_ready` for as long as it needs.

Top module: `mmd_seq`

## Requirements
- R1: After reset, `busy`, `done` and `c22_valid` are 0, `rdata` is 0 and `req_ready` is 1.
- R2: A request transfers on an edge where `req_valid` and `req_ready` are both 1, and from the next cycle `busy` is 1.
- R3: The first operation writes Clause-22 register 13 (0x0D) with bits 15:14 = 0 (the address command) and bits 4:0 = the device address. All other bits are 0.
- R4: The second operation writes Clause-22 register 14 (0x0E) with the 16-bit register address.
- R5: The third operation writes register 13 with bits 15:14 = 1 (the data command, so the value is 0x4000 | device address).
- R6: The fourth operation uses register 14. It is a write carrying `req_wdata` when `req_write` = 1, and a read when `req_write` = 0.
- R7: All four operations carry the PHY address of the request on `c22_phy`.
- R8: Only one operation is outstanding at a time, and the next one is offered only after `c22_rsp_valid`. While `c22_valid` = 1 and `c22_ready` = 0, `c22_valid`, `c22_write`, `c22_regnum` and `c22_wdata` stay unchanged.
- R9: `done` is 1 for exactly one cycle, in the cycle after the edge that takes the fourth response. `busy` is 0 in that same cycle.
- R10: For a read, `rdata` takes `c22_rsp_rdata` of the fourth response when `done` rises. After that, `rdata` only changes when a later read completes. A write leaves it unchanged.
- R11: While `busy` = 1, `req_ready` is 0. A request presented during that time starts no operations and changes no PHY state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write MMD register, 0 = read |
| req_phy | input | 5 | PHY address |
| req_devad | input | 5 | MMD device address |
| req_reg | input | 16 | MMD register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Data from the last completed read |
| c22_valid | output | 1 | Clause-22 operation offered |
| c22_ready | input | 1 | Frame engine accepts the operation |
| c22_write | output | 1 | 1 = write, 0 = read |
| c22_phy | output | 5 | PHY address of the operation |
| c22_regnum | output | 5 | Clause-22 register number |
| c22_wdata | output | 16 | Write data of the operation |
| c22_rsp_valid | input | 1 | Operation finished |
| c22_rsp_rdata | input | 16 | Read data of a finished read |

## Verification
After a request transfers at edge k, `busy` and `c22_valid` are high from edge k. Each operation holds `c22_valid` until its handshake edge, and the next operation appears one cycle after the edge that takes the response. `done` and `rdata` update at the edge that takes the fourth response, and `done` falls one edge later. The bench drives inputs and samples outputs on falling edges. Its PHY model returns each response exactly one cycle after the handshake. After `done` is seen, the bench checks the logged operation sequence, `rdata` and `busy`, and it checks `done` low again one falling edge later.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  localparam int CMD_W  = 2;
  localparam int N_OPS  = 4;
  localparam int STEP_W = $clog2(N_OPS);

  localparam logic [ADDR_W-1:0] CTRL_REGNUM = 5'h0D;
  localparam logic [ADDR_W-1:0] DATA_REGNUM = 5'h0E;
  localparam logic [CMD_W-1:0]  CMD_ADDRESS = 2'd0;
  localparam logic [CMD_W-1:0]  CMD_DATA    = 2'd1;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_state_t;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] regnum;
    logic [DATA_W-1:0] data;
  } c22_op_t;
endpackage

// File: rtl/mmd_step_gen.sv
module mmd_step_gen
  import mmd_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] devad,
  input  logic [DATA_W-1:0] regaddr,
  input  logic [DATA_W-1:0] wdata,
  output c22_op_t           op
);
  localparam int PAD_W = DATA_W - CMD_W - ADDR_W;

  function automatic logic [DATA_W-1:0] ctrl_word(input logic [CMD_W-1:0] cmd,
                                                  input logic [ADDR_W-1:0] dev);
    return {cmd, {PAD_W{1'b0}}, dev};
  endfunction

  always_comb begin
    op = '0;
    case (step)
      2'd0: begin op.wr = 1'b1; op.regnum = CTRL_REGNUM; op.data = ctrl_word(CMD_ADDRESS, devad); end
      2'd1: begin op.wr = 1'b1; op.regnum = DATA_REGNUM; op.data = regaddr; end
      2'd2: begin op.wr = 1'b1; op.regnum = CTRL_REGNUM; op.data = ctrl_word(CMD_DATA, devad); end
      default: begin
        op.wr     = is_write;
        op.regnum = DATA_REGNUM;
        op.data   = is_write ? wdata : '0;
      end
    endcase
  end
endmodule

// File: rtl/mmd_seq_ctrl.sv
module mmd_seq_ctrl
  import mmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_ready,
  input  logic              rsp_valid,
  output logic              busy,
  output logic              issue,
  output logic [STEP_W-1:0] step,
  output logic              finish
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_OPS - 1);

  seq_state_t state;

  assign busy   = (state != ST_IDLE);
  assign issue  = (state == ST_ISSUE);
  assign finish = (state == ST_WAIT) && rsp_valid && (step == LAST_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (start) begin state <= ST_ISSUE; step <= '0; end
        ST_ISSUE: if (op_ready) state <= ST_WAIT;
        ST_WAIT:  if (rsp_valid) begin
                    if (step == LAST_STEP) state <= ST_IDLE;
                    else begin state <= ST_ISSUE; step <= step + 1'b1; end
                  end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R8: no new operation while the current response is still pending
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !rsp_valid) |=> (state == ST_WAIT && $stable(step)));
endmodule

// File: rtl/mmd_seq.sv
module mmd_seq
  import mmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_devad,
  input  logic [DATA_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              c22_valid,
  input  logic              c22_ready,
  output logic              c22_write,
  output logic [ADDR_W-1:0] c22_phy,
  output logic [ADDR_W-1:0] c22_regnum,
  output logic [DATA_W-1:0] c22_wdata,
  input  logic              c22_rsp_valid,
  input  logic [DATA_W-1:0] c22_rsp_rdata
);
  logic              start, finish;
  logic [STEP_W-1:0] step;
  logic              wr_q;
  logic [ADDR_W-1:0] phy_q, dev_q;
  logic [DATA_W-1:0] reg_q, wd_q;
  c22_op_t           op;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= 1'b0; phy_q <= '0; dev_q <= '0; reg_q <= '0; wd_q <= '0;
    end else if (start) begin
      wr_q <= req_write; phy_q <= req_phy; dev_q <= req_devad;
      reg_q <= req_reg; wd_q <= req_wdata;
    end
  end

  mmd_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_ready(c22_ready),
    .rsp_valid(c22_rsp_valid), .busy(busy), .issue(c22_valid),
    .step(step), .finish(finish)
  );

  mmd_step_gen u_gen (
    .step(step), .is_write(wr_q), .devad(dev_q), .regaddr(reg_q),
    .wdata(wd_q), .op(op)
  );

  assign c22_write  = op.wr;
  assign c22_regnum = op.regnum;
  assign c22_wdata  = op.data;
  assign c22_phy    = phy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= finish;
      if (finish && !wr_q) rdata <= c22_rsp_rdata;
    end
  end

  // R2: accepted request makes the block busy
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  // R8: offered operation stays put under back-pressure
  a_r8_hold_op: assert property (@(posedge clk) disable iff (!rst_n)
    (c22_valid && !c22_ready) |=> (c22_valid && $stable(c22_write)
      && $stable(c22_regnum) && $stable(c22_wdata) && $stable(c22_phy)));
  // R9: done is a single-cycle pulse with busy low
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10: read data moves only together with completion
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done);
endmodule

// File: tb/mmd_seq_test.sv
module mmd_seq_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_devad = '0;
  logic [15:0] req_reg = '0, req_wdata = '0;
  logic req_ready, busy, done;
  logic [15:0] rdata;
  logic c22_valid, c22_write;
  logic c22_ready = 1'b1;
  logic [4:0] c22_phy, c22_regnum;
  logic [15:0] c22_wdata;
  logic c22_rsp_valid = 1'b0;
  logic [15:0] c22_rsp_rdata = '0;

  int n_checks = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  mmd_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_devad(req_devad),
    .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .c22_valid(c22_valid), .c22_ready(c22_ready),
    .c22_write(c22_write), .c22_phy(c22_phy), .c22_regnum(c22_regnum),
    .c22_wdata(c22_wdata), .c22_rsp_valid(c22_rsp_valid),
    .c22_rsp_rdata(c22_rsp_rdata)
  );

  // ---- model PHY with MMD control/data register pair ----
  logic [15:0] m_ctl = '0;
  logic [15:0] m_addr [32];
  logic [15:0] m_mem  [64];
  logic        pend = 1'b0;
  logic [15:0] pend_data = '0;
  int stall = 0;
  int op_cnt = 0;
  logic        lg_w   [8];
  logic [4:0]  lg_phy [8];
  logic [4:0]  lg_reg [8];
  logic [15:0] lg_dat [8];

  initial begin
    for (int i = 0; i < 32; i++) m_addr[i] = '0;
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
  end

  function automatic int midx(input logic [4:0] d, input logic [15:0] a);
    return int'({d[1:0], a[3:0]});
  endfunction

  always @(negedge clk) begin
    if (c22_rsp_valid) c22_rsp_valid = 1'b0;
    if (pend) begin c22_rsp_valid = 1'b1; c22_rsp_rdata = pend_data; pend = 1'b0; end
    if (c22_valid && stall > 0) begin stall--; c22_ready = 1'b0; end
    else c22_ready = 1'b1;
    if (c22_valid && c22_ready) begin
      if (op_cnt < 8) begin
        lg_w[op_cnt] = c22_write; lg_phy[op_cnt] = c22_phy;
        lg_reg[op_cnt] = c22_regnum; lg_dat[op_cnt] = c22_wdata;
      end
      op_cnt++;
      pend_data = '0;
      if (c22_regnum == 5'h0D) begin
        if (c22_write) m_ctl = c22_wdata; else pend_data = m_ctl;
      end else if (c22_regnum == 5'h0E) begin
        if (m_ctl[15:14] == 2'd0) begin
          if (c22_write) m_addr[m_ctl[4:0]] = c22_wdata;
          else pend_data = m_addr[m_ctl[4:0]];
        end else begin
          if (c22_write) m_mem[midx(m_ctl[4:0], m_addr[m_ctl[4:0]])] = c22_wdata;
          else pend_data = m_mem[midx(m_ctl[4:0], m_addr[m_ctl[4:0]])];
        end
      end
      pend = 1'b1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // run one access; leaves the bench at the negedge where done is high
  task automatic access(input logic w, input logic [4:0] phy, input logic [4:0] dev,
                        input logic [15:0] ra, input logic [15:0] wd);
    int guard;
    op_cnt = 0;
    req_write = w; req_phy = phy; req_devad = dev; req_reg = ra; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 busy after accept", 32'(busy), 32'd1);
    guard = 0;
    while (!done && guard < 200) begin @(negedge clk); guard++; end
  endtask

  task automatic check_seq(input logic w, input logic [4:0] phy, input logic [4:0] dev,
                           input logic [15:0] ra, input logic [15:0] wd);
    check("R8 op count", 32'(op_cnt), 32'd4);
    for (int i = 0; i < 4; i++) check("R7 phy", 32'(lg_phy[i]), 32'(phy));
    check("R3 op1", {lg_w[0], 10'd0, lg_reg[0], lg_dat[0]}, {1'b1, 10'd0, 5'h0D, 16'(dev)});
    check("R4 op2", {lg_w[1], 10'd0, lg_reg[1], lg_dat[1]}, {1'b1, 10'd0, 5'h0E, ra});
    check("R5 op3", {lg_w[2], 10'd0, lg_reg[2], lg_dat[2]}, {1'b1, 10'd0, 5'h0D, 16'h4000 | 16'(dev)});
    check("R6 op4", {lg_w[3], 10'd0, lg_reg[3]}, {w, 10'd0, 5'h0E});
    if (w) check("R6 op4 data", 32'(lg_dat[3]), 32'(wd));
  endtask

  typedef struct packed {
    logic w; logic [4:0] phy; logic [4:0] dev; logic [15:0] ra; logic [15:0] wd; logic [15:0] exp;
  } vec_t;
  localparam vec_t VEC [7] = '{
    '{1'b1, 5'd1,  5'd3,  16'h0005, 16'hA5A5, 16'h0000},
    '{1'b1, 5'd2,  5'd7,  16'h1234, 16'h5A5A, 16'h0000},
    '{1'b0, 5'd1,  5'd3,  16'h0005, 16'h0000, 16'hA5A5},
    '{1'b0, 5'd2,  5'd7,  16'h1234, 16'h0000, 16'h5A5A},
    '{1'b1, 5'd31, 5'd31, 16'hFFFF, 16'hFFFF, 16'h0000},
    '{1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0000, 16'hFFFF},
    '{1'b0, 5'd0,  5'd0,  16'h0000, 16'h0000, 16'h0000}
  };

  initial begin
    #(PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] last_rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 c22_valid", 32'(c22_valid), 32'd0);
    check("R1 rdata", 32'(rdata), 32'd0);
    check("R1 req_ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    last_rd = '0;
    for (int i = 0; i < 7; i++) begin
      access(VEC[i].w, VEC[i].phy, VEC[i].dev, VEC[i].ra, VEC[i].wd);
      check("R9 done seen", 32'(done), 32'd1);
      check("R9 busy low at done", 32'(busy), 32'd0);
      if (!VEC[i].w) last_rd = VEC[i].exp;
      check("R10 rdata", 32'(rdata), 32'(last_rd));
      check_seq(VEC[i].w, VEC[i].phy, VEC[i].dev, VEC[i].ra, VEC[i].wd);
      @(negedge clk);
      check("R9 done one cycle", 32'(done), 32'd0);
    end

    // R10: a write after a read leaves rdata alone
    access(1'b0, 5'd4, 5'd3, 16'h0005, 16'h0);
    check("R10 read value", 32'(rdata), 32'hA5A5);
    @(negedge clk);
    access(1'b1, 5'd4, 5'd2, 16'h0003, 16'hBEEF);
    check("R10 rdata kept over write", 32'(rdata), 32'hA5A5);
    @(negedge clk);

    // R8: back-pressure on the first operation
    stall = 3;
    access(1'b1, 5'd9, 5'd5, 16'h0009, 16'h1111);
    check_seq(1'b1, 5'd9, 5'd5, 16'h0009, 16'h1111);
    @(negedge clk);

    // R11: request presented while busy is ignored
    op_cnt = 0;
    req_write = 1'b1; req_phy = 5'd3; req_devad = 5'd5; req_reg = 16'h0009; req_wdata = 16'h2222;
    req_valid = 1'b1;
    @(negedge clk);
    req_devad = 5'd6; req_reg = 16'h0002; req_wdata = 16'h3333; req_phy = 5'd8;
    for (int k = 0; k < 40 && !done; k++) begin
      check("R11 req_ready low while busy", 32'(req_ready), 32'(!busy));
      @(negedge clk);
    end
    req_valid = 1'b0;
    check_seq(1'b1, 5'd3, 5'd5, 16'h0009, 16'h2222);
    @(negedge clk);
    check("R11 no extra operations", 32'(op_cnt), 32'd4);
    check("R11 still idle", 32'(busy), 32'd0);
    access(1'b0, 5'd3, 5'd6, 16'h0002, 16'h0);
    check("R11 ignored write had no effect", 32'(rdata), 32'h0000);
    @(negedge clk);
    access(1'b0, 5'd3, 5'd5, 16'h0009, 16'h0);
    check("R11 first write landed", 32'(rdata), 32'h2222);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule